// File: doc/BRIEF.md
# Segmented LRU Replacement Controller

This block holds the replacement state for a small fully associative cache of `NUM_ENTRIES` lines. The lines are split into two recency-ordered groups. The probationary group takes newly filled lines. The protected group takes lines that have been referenced again after their fill. Lines are always evicted from the probationary group. A line that was touched only once therefore leaves before a line that has proven it is reused. This keeps one pass over streaming data from flushing the useful working set.

Each clock the block can accept one access. An access carries an entry index and a flag that says whether it was a hit or a fill after a miss. The block then rewrites a per-entry valid bit, a segment bit and a rank. Rank 0 is the most recently used line within its own segment. The parameter `PROT_LIMIT` caps the size of the protected group. When a promotion would exceed that cap, the oldest protected line drops back to the young end of the probationary group in the same cycle. The victim index for the next fill is always available at the outputs.

Tag comparison, data arrays and the miss datapath live outside this block. The surrounding cache looks up the tag, reports the result here, and fills the line that `victimIdx` names.

Top module: `slru_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every valid bit, segment bit and rank to 0, so `entValid`, `segTag` and `rankFlat` all read 0 after that edge.
- R2: A miss access (`accValid`=1, `accHit`=0) on index i makes entry i valid and probationary (`segTag` bit 0) with rank 0. Every other probationary entry that was younger than i's old position, or every other probationary entry if i was not probationary, moves one rank older.
- R3: A hit on a valid probationary entry while the protected group holds fewer than `PROT_LIMIT` entries does three things in one cycle: the entry moves to protected (`segTag` bit 1) at rank 0, every protected entry ages by one, and the probationary entries older than it move one rank younger.
- R4: A hit on a valid probationary entry while the protected group holds `PROT_LIMIT` entries also moves the protected entry of rank `PROT_LIMIT-1` to probationary rank 0, in that same cycle. Both group sizes stay unchanged.
- R5: A hit on a protected entry moves it to protected rank 0 and ages only the protected entries that were younger than it. Probationary entries keep their ranks.
- R6: The number of valid protected entries never exceeds `PROT_LIMIT`.
- R7: `victimIdx` names the lowest-numbered invalid entry when one exists. Otherwise it names the probationary entry with the oldest rank (rank = probationary count minus 1). `victimValid` is high whenever one of these exists.
- R8: After every update, the ranks of the valid entries in each segment are exactly 0 to (segment size minus 1), with no gaps and no repeats.
- R9: A cycle with `accValid` low, and a hit access naming an invalid entry, both leave all valid bits, segment bits and ranks unchanged.
- R10: A miss on an entry that is already valid first removes it from its old place in either segment, closing the gap, and then inserts it at probationary rank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| accValid | input | 1 | An access is presented this cycle |
| accHit | input | 1 | 1 = hit on `accIdx`, 0 = fill of `accIdx` after a miss |
| accIdx | input | IDX_W | Entry index the access names |
| entValid | output | NUM_ENTRIES | Per-entry valid bit |
| segTag | output | NUM_ENTRIES | Per-entry segment: 1 = protected, 0 = probationary |
| rankFlat | output | NUM_ENTRIES*IDX_W | Per-entry rank within its segment; entry e at bits [e*IDX_W +: IDX_W], 0 = most recent |
| victimIdx | output | IDX_W | Entry to fill on the next miss |
| victimValid | output | 1 | `victimIdx` names a usable entry |

## Verification
The bound checker watches these properties on every cycle:
- the protected group stays within its cap;
- each segment's ranks form a dense permutation;
- a filled line lands at probationary rank 0, and a hit line lands at protected rank 0;
- a demotion leaves both group sizes unchanged;
- the victim is never a protected valid line;
- idle cycles change nothing.

Some behaviours cannot be written as single-cycle properties and only the bench's scenarios show them. These are the exact relative order after long mixed sequences, which line is demoted, the choice of the lowest invalid index, and the closing of the gap when a line is refilled. The bench compares every rank, segment bit and victim index against a two-queue reference model after each access.

// File: rtl/slru_pkg.sv
package slru_pkg;

  // Strobes from the control to the ordering datapath
  typedef struct packed {
    logic upd;        // apply an access this cycle
    logic isHit;      // 1 = promotion, 0 = fill
    logic tgtValid;   // target entry was valid before the access
    logic fromProt;   // target entry was protected before the access
    logic demote;     // protected oldest line drops to probationary
  } slru_strb_t;

endpackage

// File: rtl/slru_order_dp.sv
module slru_order_dp
  import slru_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PROT_LIMIT  = 4,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  slru_strb_t                   strb,
  input  logic [IDX_W-1:0]             tgtIdx,
  input  logic [IDX_W-1:0]             tgtRank,
  output logic [NUM_ENTRIES-1:0]       entValid,
  output logic [NUM_ENTRIES-1:0]       entProt,
  output logic [NUM_ENTRIES*IDX_W-1:0] entRank
);

  localparam logic [IDX_W-1:0] PROT_OLDEST = IDX_W'(PROT_LIMIT - 1);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic             vQ, pQ;
    logic [IDX_W-1:0] rQ;
    logic             pNext;
    logic [IDX_W-1:0] rNext;

    // Where this entry goes when another entry is the access target
    always_comb begin
      pNext = pQ;
      rNext = rQ;
      if (!strb.isHit) begin
        if (!pQ) begin
          if (!(strb.tgtValid && !strb.fromProt) || rQ < tgtRank) rNext = rQ + 1'b1;
        end else if (strb.tgtValid && strb.fromProt && rQ > tgtRank) begin
          rNext = rQ - 1'b1;
        end
      end else if (strb.fromProt) begin
        if (pQ && rQ < tgtRank) rNext = rQ + 1'b1;
      end else if (!pQ) begin
        if (strb.demote) begin
          if (rQ < tgtRank) rNext = rQ + 1'b1;
        end else if (rQ > tgtRank) begin
          rNext = rQ - 1'b1;
        end
      end else if (strb.demote && rQ == PROT_OLDEST) begin
        pNext = 1'b0;
        rNext = '0;
      end else begin
        rNext = rQ + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vQ <= 1'b0;
        pQ <= 1'b0;
        rQ <= '0;
      end else if (strb.upd) begin
        if (tgtIdx == IDX_W'(e)) begin
          vQ <= 1'b1;
          pQ <= strb.isHit;
          rQ <= '0;
        end else if (vQ) begin
          pQ <= pNext;
          rQ <= rNext;
        end
      end
    end

    assign entValid[e]                 = vQ;
    assign entProt[e]                  = pQ;
    assign entRank[e*IDX_W +: IDX_W]   = rQ;
  end

endmodule

// File: rtl/slru_order_ctl.sv
module slru_order_ctl
  import slru_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PROT_LIMIT  = 4,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                         accValid,
  input  logic                         accHit,
  input  logic [IDX_W-1:0]             accIdx,
  input  logic [NUM_ENTRIES-1:0]       entValid,
  input  logic [NUM_ENTRIES-1:0]       entProt,
  input  logic [NUM_ENTRIES*IDX_W-1:0] entRank,
  output slru_strb_t                   strb,
  output logic [IDX_W-1:0]             tgtIdx,
  output logic [IDX_W-1:0]             tgtRank,
  output logic [IDX_W-1:0]             victimIdx,
  output logic                         victimValid
);

  logic [CNT_W-1:0] protCount, probCount, probLast;
  logic             anyInvalid, tgtValid;
  logic [IDX_W-1:0] freeIdx, oldIdx;

  always_comb begin
    protCount = '0;
    probCount = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (entValid[e] && entProt[e])  protCount = protCount + 1'b1;
      if (entValid[e] && !entProt[e]) probCount = probCount + 1'b1;
    end
  end

  assign probLast = probCount - CNT_W'(1);

  // Victim: lowest invalid index first, else oldest probationary line
  always_comb begin
    anyInvalid = 1'b0;
    freeIdx    = '0;
    oldIdx     = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (!entValid[e]) begin
        anyInvalid = 1'b1;
        freeIdx    = IDX_W'(e);
      end
      if (entValid[e] && !entProt[e] &&
          entRank[e*IDX_W +: IDX_W] == IDX_W'(probLast))
        oldIdx = IDX_W'(e);
    end
  end

  assign victimIdx   = anyInvalid ? freeIdx : oldIdx;
  assign victimValid = anyInvalid || (probCount != '0);

  assign tgtIdx   = accIdx;
  assign tgtValid = entValid[accIdx];
  assign tgtRank  = entRank[accIdx*IDX_W +: IDX_W];

  always_comb begin
    strb.isHit    = accHit;
    strb.tgtValid = tgtValid;
    strb.fromProt = tgtValid && entProt[accIdx];
    strb.upd      = accValid && (!accHit || tgtValid);
    strb.demote   = accHit && tgtValid && !entProt[accIdx] &&
                    (protCount == CNT_W'(PROT_LIMIT));
  end

endmodule

// File: rtl/slru_ctrl.sv
module slru_ctrl
  import slru_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PROT_LIMIT  = 4,   // must be below NUM_ENTRIES
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         accValid,
  input  logic                         accHit,
  input  logic [IDX_W-1:0]             accIdx,
  output logic [NUM_ENTRIES-1:0]       entValid,
  output logic [NUM_ENTRIES-1:0]       segTag,
  output logic [NUM_ENTRIES*IDX_W-1:0] rankFlat,
  output logic [IDX_W-1:0]             victimIdx,
  output logic                         victimValid
);

  slru_strb_t       strb;
  logic [IDX_W-1:0] tgtIdx, tgtRank;

  slru_order_ctl #(.NUM_ENTRIES(NUM_ENTRIES), .PROT_LIMIT(PROT_LIMIT)) u_ctl (
    .accValid(accValid), .accHit(accHit), .accIdx(accIdx),
    .entValid(entValid), .entProt(segTag), .entRank(rankFlat),
    .strb(strb), .tgtIdx(tgtIdx), .tgtRank(tgtRank),
    .victimIdx(victimIdx), .victimValid(victimValid)
  );

  slru_order_dp #(.NUM_ENTRIES(NUM_ENTRIES), .PROT_LIMIT(PROT_LIMIT)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .tgtIdx(tgtIdx), .tgtRank(tgtRank),
    .entValid(entValid), .entProt(segTag), .entRank(rankFlat)
  );

endmodule

// File: rtl/slru_ctrl_chk.sv
module slru_ctrl_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int PROT_LIMIT  = 4,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         accValid,
  input logic                         accHit,
  input logic [IDX_W-1:0]             accIdx,
  input logic [NUM_ENTRIES-1:0]       entValid,
  input logic [NUM_ENTRIES-1:0]       segTag,
  input logic [NUM_ENTRIES*IDX_W-1:0] rankFlat,
  input logic [IDX_W-1:0]             victimIdx,
  input logic                         victimValid
);

  logic [CNT_W-1:0]       protCnt, probCnt;
  logic [NUM_ENTRIES-1:0] protMask, probMask, protWant, probWant;

  always_comb begin
    protCnt  = '0;
    probCnt  = '0;
    protMask = '0;
    probMask = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (entValid[e]) begin
        if (segTag[e]) begin
          protCnt = protCnt + 1'b1;
          protMask[rankFlat[e*IDX_W +: IDX_W]] = 1'b1;
        end else begin
          probCnt = probCnt + 1'b1;
          probMask[rankFlat[e*IDX_W +: IDX_W]] = 1'b1;
        end
      end
    end
    protWant = '0;
    probWant = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      protWant[k] = (CNT_W'(k) < protCnt);
      probWant[k] = (CNT_W'(k) < probCnt);
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (entValid == '0) && (segTag == '0) && (rankFlat == '0));

  a_r2_fill_lands_young: assert property (@(posedge clk) disable iff (rst)
    accValid && !accHit |=> entValid[$past(accIdx)] && !segTag[$past(accIdx)] &&
                            rankFlat[$past(accIdx)*IDX_W +: IDX_W] == '0);

  a_r3_hit_lands_prot: assert property (@(posedge clk) disable iff (rst)
    accValid && accHit && entValid[accIdx] |=> segTag[$past(accIdx)] &&
                            rankFlat[$past(accIdx)*IDX_W +: IDX_W] == '0);

  a_r4_demote_keeps_sizes: assert property (@(posedge clk) disable iff (rst)
    accValid && accHit && entValid[accIdx] && !segTag[accIdx] &&
    protCnt == CNT_W'(PROT_LIMIT) |=> $stable(protCnt) && $stable(probCnt));

  a_r6_prot_cap: assert property (@(posedge clk) disable iff (rst)
    protCnt <= CNT_W'(PROT_LIMIT));

  a_r7_victim_not_prot: assert property (@(posedge clk) disable iff (rst)
    victimValid && entValid[victimIdx] |-> !segTag[victimIdx]);

  a_r8_rank_perm: assert property (@(posedge clk) disable iff (rst)
    (protMask == protWant) && (probMask == probWant));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !accValid |=> $stable(entValid) && $stable(segTag) && $stable(rankFlat));

endmodule

bind slru_ctrl slru_ctrl_chk #(.NUM_ENTRIES(NUM_ENTRIES), .PROT_LIMIT(PROT_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .accValid(accValid), .accHit(accHit), .accIdx(accIdx),
  .entValid(entValid), .segTag(segTag), .rankFlat(rankFlat),
  .victimIdx(victimIdx), .victimValid(victimValid)
);

// File: tb/slru_ctrl_test.sv
module slru_ctrl_test;
  localparam int N          = 8;
  localparam int PL         = 4;
  localparam int IW         = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            accValid = 1'b0, accHit = 1'b0;
  logic [IW-1:0]   accIdx = '0;
  logic [N-1:0]    entValid, segTag;
  logic [N*IW-1:0] rankFlat;
  logic [IW-1:0]   victimIdx;
  logic            victimValid;

  slru_ctrl #(.NUM_ENTRIES(N), .PROT_LIMIT(PL)) uut (
    .clk(clk), .rst(rst), .accValid(accValid), .accHit(accHit), .accIdx(accIdx),
    .entValid(entValid), .segTag(segTag), .rankFlat(rankFlat),
    .victimIdx(victimIdx), .victimValid(victimValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int probQ[$];
  int protQ[$];
  bit mValid[N];
  int nRun = 0, nFail = 0;

  function automatic int modelVictim();
    for (int e = 0; e < N; e++) if (!mValid[e]) return e;
    return probQ[probQ.size()-1];
  endfunction

  function automatic bit dropFrom(ref int q[$], input int idx);
    for (int k = 0; k < q.size(); k++)
      if (q[k] == idx) begin q.delete(k); return 1; end
    return 0;
  endfunction

  task automatic modelAccess(bit hit, int idx);
    bit wasProb;
    if (hit && !mValid[idx]) return;
    wasProb = dropFrom(probQ, idx);
    void'(dropFrom(protQ, idx));
    if (!hit) begin
      probQ.push_front(idx);
      mValid[idx] = 1;
    end else begin
      if (wasProb && protQ.size() == PL) probQ.push_front(protQ.pop_back());
      protQ.push_front(idx);
    end
  endtask

  task automatic checkAll(string req);
    logic [N-1:0]    eV = '0, eS = '0;
    logic [N*IW-1:0] eR = '0;
    int              eVic = modelVictim();
    foreach (probQ[k]) begin eV[probQ[k]] = 1; eR[probQ[k]*IW +: IW] = IW'(k); end
    foreach (protQ[k]) begin
      eV[protQ[k]] = 1; eS[protQ[k]] = 1; eR[protQ[k]*IW +: IW] = IW'(k);
    end
    nRun++;
    if (entValid !== eV || segTag !== eS || rankFlat !== eR ||
        victimIdx !== IW'(eVic) || victimValid !== 1'b1) begin
      nFail++;
      $display("FAIL %s: valid=%b seg=%b rank=%h vic=%0d/%b expected valid=%b seg=%b rank=%h vic=%0d/1",
               req, entValid, segTag, rankFlat, victimIdx, victimValid, eV, eS, eR, eVic);
    end
  endtask

  task automatic access(bit hit, int idx, string req);
    accValid = 1'b1; accHit = hit; accIdx = IW'(idx);
    @(negedge clk);
    accValid = 1'b0;
    modelAccess(hit, idx);
    checkAll(req);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    probQ.delete(); protQ.delete();
    foreach (mValid[e]) mValid[e] = 0;
    checkAll("R1 reset");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h51a7));
    @(negedge clk);
    doReset();
    access(1, 3, "R9 hit on invalid entry");
    accHit = 1'b1; @(negedge clk); checkAll("R9 idle cycle");
    for (int i = 0; i < N; i++) access(0, modelVictim(), "R2/R7 fill");
    for (int i = 0; i < PL; i++) access(1, i, "R3 promote");
    access(1, 5, "R4 promote with demotion");
    access(1, 6, "R4 second demotion");
    access(1, 2, "R5 hit on protected");
    access(1, 6, "R5 hit protected youngest");
    access(0, 7, "R10 refill probationary entry");
    access(0, 2, "R10 refill protected entry");
    access(0, modelVictim(), "R7 evict oldest probationary");
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 19);
      if (sel < 2) begin
        accHit = 1'b1; accIdx = IW'($urandom_range(0, N-1));
        @(negedge clk); checkAll("R9 random idle");
      end else if (sel < 11) access(1, $urandom_range(0, N-1), "R8 random hit");
      else if (sel < 17)     access(0, modelVictim(), "R8 random fill");
      else                   access(0, $urandom_range(0, N-1), "R10 random refill");
      if (i == 2000) doReset();
    end
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule